// File: doc/BRIEF.md
# Write-Completion Acknowledge Poller

A serial memory on a two-wire bus ignores the bus while it commits a write to its cells. This block polls for the end of that commit, so a system does not have to wait out the worst-case write time. On a request it sends a START condition and one device select byte: a 7-bit device address followed by a direction bit. It then releases SDA for the ninth clock and samples it. A low level is an acknowledge, which means the memory has finished and has accepted the select byte.

When there is no acknowledge, the block sends STOP and leaves the bus free for a set interval. It then tries again. The select byte that finally gets an acknowledge counts as the first byte of the caller's next instruction. The block therefore parks the bus with SCL held low and raises `ready_o`, and the caller goes straight on with the byte address or the data. When the attempt budget is used up, the block raises `timeout_o` and releases both lines. Both lines are open-drain: an output high means the line is pulled low.

Top module: `ackpoll_master`

## Requirements
- R1: During and after synchronous reset, SCL and SDA are released (`scl_pull_o` = 0, `sda_pull_o` = 0), and `ready_o` and `timeout_o` are 0.
- R2: The bus advances in quarter-bit steps. Each bus level is held for exactly `QTR_CLKS` system clocks. An attempt opens with one step where both lines are released. Next comes one step with SDA low and SCL released, which forms the START. Then comes one step with both lines low.
- R3: The select byte goes out MSB first: `dev_addr_i[6]` down to `dev_addr_i[0]`, then `rw_i` (1 = read). Each bit takes four steps with SCL low, high, high, low. The SDA level is set while SCL is low and stays steady while SCL is high.
- R4: On the ninth clock SDA is released for all four steps. SDA is sampled on the last system clock of the second high step, and a low level counts as an acknowledge.
- R5: After a missing acknowledge, the block sends a STOP: both lines low, then SCL released, then SDA released. The bus is then left free for `GAP_QTRS` steps, and a new attempt starts as in R2.
- R6: After an acknowledge, `ready_o` goes to 1 on the same clock on which the block stops clocking. SCL stays pulled low and SDA stays released. No further clock pulse or select byte is sent until the next `start_i`.
- R7: If `MAX_TRIES` attempts all go unacknowledged, the block sends the STOP of the last attempt and then releases both lines. It sets `timeout_o` to 1 until the next `start_i`.
- R8: `start_i` has no effect while a poll is in progress.
- R9: A `start_i` while `ready_o` is 1 clears `ready_o` and begins a new poll with a fresh attempt budget. The new poll opens with the R2 sequence, which forms a repeated START.
- R10: A `start_i` while `timeout_o` is 1 clears `timeout_o` and begins a new poll with the full `MAX_TRIES` budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a poll (taken when idle, ready or timed out) |
| dev_addr_i | input | 7 | Device address sent in the select byte |
| rw_i | input | 1 | Direction bit of the select byte, 1 = read |
| sda_i | input | 1 | Level sensed on the SDA line |
| scl_pull_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| ready_o | output | 1 | Memory acknowledged; bus parked for the caller |
| timeout_o | output | 1 | Attempt budget exhausted; bus released |

## Verification
The bench builds the block with `QTR_CLKS` = 2, `MAX_TRIES` = 4 and `GAP_QTRS` = 3. With these values a full attempt takes under a hundred clocks, so one short run covers an acknowledge on the first try, an acknowledge after a few refusals, an acknowledge on the very last allowed attempt and a complete timeout. The short step exposes any step that is one clock too long or too short. The small budget makes the off-by-one edge of the attempt limit cheap to reach, both from the ready state and from the timed-out state.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BITS,
    ST_STOP,
    ST_GAP,
    ST_DONE,
    ST_TOUT
  } ap_state_e;
endpackage

// File: rtl/ackpoll_tick.sv
// Quarter-bit step generator: one tick every QTR_CLKS clocks while not held.
module ackpoll_tick #(
  parameter int QTR_CLKS = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic tick
);
  localparam int CW = $clog2(QTR_CLKS + 1);

  logic [CW-1:0] cnt_q;

  assign tick = !hold && (cnt_q == CW'(QTR_CLKS - 1));

  always_ff @(posedge clk) begin
    if (rst || hold)  cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // R2: the step counter never passes its limit
  assert_step_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(QTR_CLKS));
endmodule

// File: rtl/ackpoll_tries.sv
// Counts refused attempts; spent flags an exhausted budget.
module ackpoll_tries #(
  parameter int MAX_TRIES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic fail,
  output logic spent
);
  localparam int TW = $clog2(MAX_TRIES + 1);

  logic [TW-1:0] tries_q;

  assign spent = (tries_q == TW'(MAX_TRIES));

  always_ff @(posedge clk) begin
    if (rst || clr) tries_q <= '0;
    else if (fail)  tries_q <= tries_q + 1'b1;
  end

  // R7: no failure is counted once the budget is spent
  assert_no_extra_try_R7: assert property (@(posedge clk) disable iff (rst)
    spent |-> !fail);
endmodule

// File: rtl/ackpoll_master.sv
module ackpoll_master
  import ackpoll_pkg::*;
#(
  parameter int QTR_CLKS  = 125,
  parameter int MAX_TRIES = 8,
  parameter int GAP_QTRS  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic [6:0] dev_addr_i,
  input  logic       rw_i,
  input  logic       sda_i,
  output logic       scl_pull_o,
  output logic       sda_pull_o,
  output logic       ready_o,
  output logic       timeout_o
);
  localparam int GW = $clog2(GAP_QTRS + 1);

  ap_state_e     state_q, state_n;
  logic [1:0]    ph_q, ph_n;
  logic [3:0]    bit_q, bit_n;
  logic [GW-1:0] gap_q, gap_n;
  logic [7:0]    sel_q, sel_n;
  logic          ack_q;
  logic          tick, hold, clr, fail, spent;
  logic          scl_rel_n, sda_rel_n;

  assign hold = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_TOUT);

  ackpoll_tick #(.QTR_CLKS(QTR_CLKS)) u_tick (
    .clk(clk), .rst(rst), .hold(hold), .tick(tick)
  );

  ackpoll_tries #(.MAX_TRIES(MAX_TRIES)) u_tries (
    .clk(clk), .rst(rst), .clr(clr), .fail(fail), .spent(spent)
  );

  // Next-state logic
  always_comb begin
    state_n = state_q;
    ph_n    = ph_q;
    bit_n   = bit_q;
    gap_n   = gap_q;
    sel_n   = sel_q;
    clr     = 1'b0;
    fail    = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE, ST_TOUT: begin
        if (start_i) begin
          state_n = ST_START;
          ph_n    = 2'd0;
          sel_n   = {dev_addr_i, rw_i};
          clr     = 1'b1;
        end
      end
      ST_START: begin
        if (tick) begin
          if (ph_q == 2'd2) begin
            state_n = ST_BITS;
            ph_n    = 2'd0;
            bit_n   = 4'd0;
          end else begin
            ph_n = ph_q + 2'd1;
          end
        end
      end
      ST_BITS: begin
        if (tick) begin
          if (ph_q != 2'd3) begin
            ph_n = ph_q + 2'd1;
          end else if (bit_q != 4'd8) begin
            ph_n  = 2'd0;
            bit_n = bit_q + 4'd1;
          end else if (ack_q) begin
            state_n = ST_DONE;
          end else begin
            state_n = ST_STOP;
            ph_n    = 2'd0;
            fail    = 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (tick) begin
          if (ph_q != 2'd2) begin
            ph_n = ph_q + 2'd1;
          end else if (spent) begin
            state_n = ST_TOUT;
          end else begin
            state_n = ST_GAP;
            gap_n   = '0;
          end
        end
      end
      ST_GAP: begin
        if (tick) begin
          if (gap_q == GW'(GAP_QTRS - 1)) begin
            state_n = ST_START;
            ph_n    = 2'd0;
          end else begin
            gap_n = gap_q + 1'b1;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // Bus levels decoded from the next step, so outputs move with the state
  always_comb begin
    scl_rel_n = 1'b1;
    sda_rel_n = 1'b1;
    unique case (state_n)
      ST_START: begin
        scl_rel_n = (ph_n != 2'd2);
        sda_rel_n = (ph_n == 2'd0);
      end
      ST_BITS: begin
        scl_rel_n = (ph_n == 2'd1) || (ph_n == 2'd2);
        sda_rel_n = (bit_n == 4'd8) ? 1'b1 : sel_n[3'(4'd7 - bit_n)];
      end
      ST_STOP: begin
        scl_rel_n = (ph_n != 2'd0);
        sda_rel_n = (ph_n == 2'd2);
      end
      ST_DONE: begin
        scl_rel_n = 1'b0;
        sda_rel_n = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      ph_q       <= 2'd0;
      bit_q      <= 4'd0;
      gap_q      <= '0;
      sel_q      <= 8'd0;
      ack_q      <= 1'b0;
      scl_pull_o <= 1'b0;
      sda_pull_o <= 1'b0;
      ready_o    <= 1'b0;
      timeout_o  <= 1'b0;
    end else begin
      state_q    <= state_n;
      ph_q       <= ph_n;
      bit_q      <= bit_n;
      gap_q      <= gap_n;
      sel_q      <= sel_n;
      scl_pull_o <= !scl_rel_n;
      sda_pull_o <= !sda_rel_n;
      ready_o    <= (state_n == ST_DONE);
      timeout_o  <= (state_n == ST_TOUT);
      if (state_q == ST_BITS && tick && ph_q == 2'd2 && bit_q == 4'd8)
        ack_q <= !sda_i;
    end
  end

  // R6 and R7: the two end flags are never both set
  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(ready_o && timeout_o));

  // R6: a parked bus keeps SCL low and SDA free
  assert_parked_bus_R6: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> (scl_pull_o && !sda_pull_o));

  // R7: a timed-out master lets go of both lines
  assert_released_on_timeout_R7: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> (!scl_pull_o && !sda_pull_o));

  // R3: data does not move while SCL is high inside a byte
  assert_sda_steady_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BITS && $past(state_q) == ST_BITS &&
     !scl_pull_o && !$past(scl_pull_o)) |-> (sda_pull_o == $past(sda_pull_o)));

  // R8: a request during an active poll does not restart the attempt
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (start_i && state_q == ST_BITS) |=> (state_q == ST_BITS || state_q == ST_STOP ||
                                          state_q == ST_DONE));
endmodule

// File: tb/ackpoll_master_tb.sv
module ackpoll_master_tb;
  localparam int Q    = 2;
  localparam int MAXT = 4;
  localparam int GAP  = 3;
  localparam int TAIL = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [6:0] dev_addr_i = 7'd0;
  logic rw_i = 1'b0;
  logic slv_pull = 1'b0;
  logic scl_pull_o, sda_pull_o, ready_o, timeout_o;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [3:0] exp_q[$];
  bit         slv_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  assign sda_line = !(sda_pull_o || slv_pull);

  ackpoll_master #(.QTR_CLKS(Q), .MAX_TRIES(MAXT), .GAP_QTRS(GAP)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .dev_addr_i(dev_addr_i), .rw_i(rw_i),
    .sda_i(sda_line), .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o),
    .ready_o(ready_o), .timeout_o(timeout_o)
  );

  // one bus step: levels are line levels, stored as pull values
  task automatic push_ph(input bit scl_lvl, input bit sda_lvl, input bit rdy,
                         input bit tmo, input bit slv, input string tag);
    for (int i = 0; i < Q; i++) begin
      exp_q.push_back({!scl_lvl, !sda_lvl, rdy, tmo});
      slv_q.push_back(slv);
      tag_q.push_back(tag);
    end
  endtask

  task automatic build(input logic [6:0] addr, input bit rw, input int busy,
                       input string first_tag);
    logic [7:0] sel;
    sel = {addr, rw};
    exp_q.delete(); slv_q.delete(); tag_q.delete();
    for (int a = 0; a < MAXT; a++) begin
      push_ph(1, 1, 0, 0, 0, (a == 0) ? first_tag : "R5");
      push_ph(1, 0, 0, 0, 0, "R2");
      push_ph(0, 0, 0, 0, 0, "R2");
      for (int k = 0; k < 8; k++) begin
        push_ph(0, sel[7-k], 0, 0, 0, "R3");
        push_ph(1, sel[7-k], 0, 0, 0, "R3");
        push_ph(1, sel[7-k], 0, 0, 0, "R3");
        push_ph(0, sel[7-k], 0, 0, 0, "R3");
      end
      for (int p = 0; p < 4; p++)
        push_ph((p == 1 || p == 2), 1, 0, 0, (a >= busy), "R4");
      if (a >= busy) begin
        for (int t = 0; t < TAIL; t++) push_ph(0, 1, 1, 0, 0, "R6");
        return;
      end
      push_ph(0, 0, 0, 0, 0, "R5");
      push_ph(1, 0, 0, 0, 0, "R5");
      push_ph(1, 1, 0, 0, 0, "R5");
      if (a == MAXT - 1) begin
        for (int t = 0; t < TAIL; t++) push_ph(1, 1, 0, 1, 0, "R7");
        return;
      end
      for (int g = 0; g < GAP; g++) push_ph(1, 1, 0, 0, 0, "R5");
    end
  endtask

  task automatic check(input logic [3:0] act, input logic [3:0] expv, input string tag);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: {scl_pull,sda_pull,ready,timeout} actual=%b expected=%b at %0t",
               tag, act, expv, $time);
    end
  endtask

  task automatic run(input logic [6:0] addr, input bit rw, input int busy,
                     input bit noise, input string first_tag);
    build(addr, rw, busy, first_tag);
    @(negedge clk);
    dev_addr_i = addr;
    rw_i       = rw;
    start_i    = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int idx = 0; idx < exp_q.size(); idx++) begin
      slv_pull = slv_q[idx];
      // R8: requests in the middle of a byte must leave the sequence untouched
      start_i  = noise && (idx >= 20) && (idx < 34);
      check({scl_pull_o, sda_pull_o, ready_o, timeout_o}, exp_q[idx],
            (noise && idx >= 20 && idx < 36) ? "R8" : tag_q[idx]);
      @(negedge clk);
    end
    start_i  = 1'b0;
    slv_pull = 1'b0;
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    check({scl_pull_o, sda_pull_o, ready_o, timeout_o}, 4'b0000, "R1");
    rst = 1'b0;
    @(negedge clk);
    check({scl_pull_o, sda_pull_o, ready_o, timeout_o}, 4'b0000, "R1");
    run(7'h50, 1'b0, 0, 1'b0, "R2");
    run(7'h2A, 1'b1, 2, 1'b1, "R9");
    run(7'h3F, 1'b0, 99, 1'b0, "R9");
    run(7'h41, 1'b1, 3, 1'b0, "R10");
    run(7'h15, 1'b0, 99, 1'b1, "R9");
    run(7'h6C, 1'b0, 1, 1'b0, "R10");
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule